// File: doc/BRIEF.md
# Serial Video Word Aligner

This block turns a descrambled serial video bitstream, one bit per accepted clock and least significant bit first, into 10-bit parallel words. It watches a sliding window of the last four words for the timing reference sequence, a preamble of 3FFh, 000h and 000h followed by a flag word whose bit 9 is 1. It chooses the bit phase that places that sequence on a word boundary. When a later sequence arrives at a different phase, the block either realigns or raises a misalignment flag, depending on the policy selected by two control inputs.

The policy sits in a three-state machine. SEARCH is the state after reset. No words are emitted and the first valid sequence causes *acquire* (SEARCH to LOCKED). LOCKED emits one word every ten accepted bits. An on-phase sequence is *keep*, which stays in LOCKED. An off-phase sequence is either *realign*, a LOCKED self-loop that moves the phase, or *drift* (LOCKED to SLIP). SLIP continues at the old phase with the misalignment flag raised. An on-phase sequence gives *recover* (SLIP to LOCKED). An off-phase sequence that the policy allows gives *resync* (SLIP to LOCKED, with the new phase). An off-phase sequence the policy rejects is *hold*, which stays in SLIP. The policy inputs select the behaviour as follows:

| `follow_off` | `realign_en` | Policy |
|---|---|---|
| 0 | either | Auto-follow. This is the behaviour when both inputs are tied low. |
| 1 | 0 | Lock-once. |
| 1 | 1 | Realign on every sequence. |

Each accepted sequence latches the field, vertical and horizontal flags from its flag word.

Top module: `vid_word_aligner`

## Requirements
- R1: After reset the outputs `word_out`, `word_vld`, `trs_pulse`, `flag_f`, `flag_v`, `flag_h` and `misalign` are all 0. No `word_vld` occurs before the first valid timing reference sequence.
- R2: A timing reference sequence consists of the words 3FFh, 000h and 000h, followed by a flag word with bit 9 set, each word sent LSB first. The first such sequence fixes the word phase. Its flag word appears on `word_out` one clock after its last bit is accepted.
- R3: While locked, `word_vld` pulses for one clock after every tenth accepted bit at the chosen phase. `word_out` then holds the last ten bits, with the earliest-received bit in bit 0.
- R4: With `follow_off`=1 and `realign_en`=0, an off-phase sequence sets `misalign`. It leaves the word phase unchanged, gives no `trs_pulse`, and leaves the flags unchanged.
- R5: In that lock-once policy, `misalign` stays set through further off-phase sequences. It clears on the first sequence that lands on the current phase, which is accepted.
- R6: With `follow_off`=1 and `realign_en`=1, every valid sequence moves the word phase to itself and `misalign` never sets.
- R7: With `follow_off`=0, an off-phase sequence sets `misalign`. The next sequence is accepted, at its own phase if needed, and clears `misalign`.
- R8: `flag_f`, `flag_v` and `flag_h` take bits 8, 7 and 6 of an accepted flag word (1 = asserted). They hold their values until the next accepted sequence.
- R9: `trs_pulse` is high for exactly one clock, together with `word_vld`, while `word_out` shows the flag word of an accepted sequence.
- R10: A clock with `bit_en`=0 consumes no bit, produces no `word_vld`, and leaves the phase and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe: `bit_in` is accepted in this clock |
| bit_in | input | 1 | Serial data, LSB of each word first |
| follow_off | input | 1 | 0 selects auto-follow; 1 selects the lock-once or every-sequence policy |
| realign_en | input | 1 | With `follow_off`=1, realign on every sequence |
| word_out | output | 10 | Aligned parallel word |
| word_vld | output | 1 | One-clock strobe per emitted word |
| trs_pulse | output | 1 | Flag word of an accepted sequence is on `word_out` |
| flag_f | output | 1 | Field flag |
| flag_v | output | 1 | Vertical blanking flag |
| flag_h | output | 1 | Horizontal flag (end/start of active video) |
| misalign | output | 1 | An off-phase sequence has been seen and not yet resolved |

## Verification
A wrong phase counter or a wrong state shows up within one word time. `word_vld` then lands on the wrong bit, or `word_out` holds a rotated word, so every emitted word after the fault fails its comparison. A wrong policy decision shows up at the next sequence. `misalign` then rises or fails to clear on the bit that completes the flag word, and the flag outputs either move when they should hold or hold when they should move. Because each bit is checked against the expected phase, a slip of one bit in any scenario shows up before the following word completes.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_LOCKED = 2'd1,
        ST_SLIP   = 2'd2
    } algn_st_t;

    localparam int PRE_WORDS = 3;
endpackage

// File: rtl/vfa_trs_window.sv
module vfa_trs_window #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic         hit,
    output logic [W-1:0] last_word
);
    import vfa_pkg::*;
    localparam int WIN = (PRE_WORDS + 1) * W;

    logic [WIN-2:0]       hist_q;
    logic [WIN-1:0]       win_d;
    logic [PRE_WORDS-1:0] seg_ok;

    // newest bit enters at the top; the oldest preamble word sits lowest
    assign win_d = {bit_in, hist_q};

    always_ff @(posedge clk) begin
        if (!rst_n)      hist_q <= '0;
        else if (bit_en) hist_q <= win_d[WIN-1:1];
    end

    generate
        for (genvar g = 0; g < PRE_WORDS; g++) begin : g_seg
            if (g == 0) begin : g_ones
                assign seg_ok[g] = &win_d[W-1:0];
            end else begin : g_zeros
                assign seg_ok[g] = ~|win_d[g*W +: W];
            end
        end
    endgenerate

    assign hit       = bit_en && (&seg_ok) && win_d[WIN-1];
    assign last_word = win_d[WIN-1 -: W];
endmodule

// File: rtl/vfa_align_fsm.sv
module vfa_align_fsm #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic hit,
    input  logic follow_off,
    input  logic realign_en,
    output logic word_end,
    output logic trs_take,
    output logic misal,
    output logic locked
);
    import vfa_pkg::*;
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    algn_st_t      st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          at_bnd;
    logic          realign;

    assign at_bnd = (cnt_q == CW'(W - 1));

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_SEARCH;
            cnt_q <= '0;
        end else if (bit_en) begin
            st_q  <= st_d;
            cnt_q <= (word_end || at_bnd) ? '0 : cnt_q + 1'b1;
        end
    end

    // next state and decision outputs
    always_comb begin
        st_d    = st_q;
        realign = 1'b0;
        unique case (st_q)
            ST_SEARCH: begin
                if (hit) begin
                    realign = 1'b1;               // acquire
                    st_d    = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (hit && !at_bnd) begin
                    if (follow_off && realign_en) realign = 1'b1;   // realign
                    else                          st_d    = ST_SLIP; // drift
                end
            end
            ST_SLIP: begin
                if (hit) begin
                    if (at_bnd) begin
                        st_d = ST_LOCKED;         // recover
                    end else if (!follow_off || realign_en) begin
                        realign = 1'b1;           // resync
                        st_d    = ST_LOCKED;
                    end
                end
            end
            default: st_d = ST_SEARCH;
        endcase
        word_end = bit_en && (((st_q != ST_SEARCH) && at_bnd) || realign);
        trs_take = hit && word_end;
        misal    = (st_q == ST_SLIP);
        locked   = (st_q != ST_SEARCH);
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(W));
    p_no_emit_search_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEARCH && !hit) |-> !word_end);
    p_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLIP && hit && at_bnd) |=> st_q == ST_LOCKED);
    p_never_slip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (follow_off && realign_en && st_q != ST_SLIP) |=> st_q != ST_SLIP);
    p_auto_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLIP && hit && !follow_off) |=> st_q == ST_LOCKED);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(st_q) && $stable(cnt_q)));
endmodule

// File: rtl/vfa_word_emit.sv
module vfa_word_emit #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_end,
    input  logic         trs_take,
    input  logic [W-1:0] last_word,
    output logic [W-1:0] word_q,
    output logic         vld_q,
    output logic         trs_q,
    output logic         f_q,
    output logic         v_q,
    output logic         h_q
);
    localparam int F_BIT = W - 2;
    localparam int V_BIT = W - 3;
    localparam int H_BIT = W - 4;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
            trs_q  <= 1'b0;
            f_q    <= 1'b0;
            v_q    <= 1'b0;
            h_q    <= 1'b0;
        end else begin
            vld_q <= word_end;
            trs_q <= trs_take;
            if (word_end) word_q <= last_word;
            if (trs_take) begin
                f_q <= last_word[F_BIT];
                v_q <= last_word[V_BIT];
                h_q <= last_word[H_BIT];
            end
        end
    end

    p_pulse_with_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trs_q |-> (vld_q && word_q[W-1]));
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trs_q |=> !trs_q);
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trs_take |=> $stable({f_q, v_q, h_q}));
endmodule

// File: rtl/vid_word_aligner.sv
module vid_word_aligner #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         follow_off,
    input  logic         realign_en,
    output logic [W-1:0] word_out,
    output logic         word_vld,
    output logic         trs_pulse,
    output logic         flag_f,
    output logic         flag_v,
    output logic         flag_h,
    output logic         misalign
);
    logic         hit;
    logic [W-1:0] last_word;
    logic         word_end;
    logic         trs_take;
    logic         locked;

    vfa_trs_window #(.W(W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .hit       (hit),
        .last_word (last_word)
    );

    vfa_align_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .hit        (hit),
        .follow_off (follow_off),
        .realign_en (realign_en),
        .word_end   (word_end),
        .trs_take   (trs_take),
        .misal      (misalign),
        .locked     (locked)
    );

    vfa_word_emit #(.W(W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_end  (word_end),
        .trs_take  (trs_take),
        .last_word (last_word),
        .word_q    (word_out),
        .vld_q     (word_vld),
        .trs_q     (trs_pulse),
        .f_q       (flag_f),
        .v_q       (flag_v),
        .h_q       (flag_h)
    );

    p_misal_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> locked);
endmodule

// File: tb/vid_word_aligner_tb.sv
`timescale 1ns/1ps
module vid_word_aligner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       follow_off = 1'b0;
    logic       realign_en = 1'b0;
    logic [9:0] word_out;
    logic       word_vld, trs_pulse, flag_f, flag_v, flag_h, misalign;

    always #2.5 clk = ~clk;

    vid_word_aligner #(.W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .follow_off(follow_off), .realign_en(realign_en),
        .word_out(word_out), .word_vld(word_vld), .trs_pulse(trs_pulse),
        .flag_f(flag_f), .flag_v(flag_v), .flag_h(flag_h), .misalign(misalign)
    );

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    bit         sb    [0:4095];
    bit         e_vld [0:4095];
    logic [9:0] e_dat [0:4095];
    bit         e_trs [0:4095];
    bit         e_mis [0:4095];
    logic [2:0] e_fvh [0:4095];
    int n, anchor, first_lock, fc;
    bit lk, mis;
    logic [2:0] fvh;

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic build_init();
        n = 0; anchor = 0; lk = 0; mis = 0; fvh = 3'b000; first_lock = 1 << 30;
    endtask

    task automatic put_bit(bit b);
        sb[n]    = b;
        e_vld[n] = lk && (n > anchor) && ((n - anchor) % 10 == 0);
        e_dat[n] = '0;
        if (e_vld[n] && n >= 9)
            for (int k = 0; k < 10; k++) e_dat[n][k] = sb[n - 9 + k];
        e_trs[n] = 1'b0;
        e_mis[n] = mis;
        e_fvh[n] = fvh;
        n++;
    endtask

    task automatic put_word(logic [9:0] w);
        for (int k = 0; k < 10; k++) put_bit(w[k]);
    endtask

    task automatic put_fill(int cnt);
        for (int i = 0; i < cnt; i++) begin
            put_word(10'h100 | 10'((fc * 37 + 11) & 8'hFF));
            fc++;
        end
    endtask

    task automatic put_slip(int s);
        for (int i = 0; i < s; i++) put_bit(1'b0);
    endtask

    // accept=1: the sequence must be taken; accept=0: it must be rejected
    task automatic put_trs(logic [2:0] f3, bit accept);
        logic [9:0] xyz;
        int j;
        xyz = {1'b1, f3, 6'b000100};
        put_word(10'h3FF); put_word(10'h000); put_word(10'h000);
        put_word(xyz);
        j = n - 1;
        if (accept) begin
            if (!lk) first_lock = j;
            lk = 1; anchor = j; mis = 0; fvh = f3;
            e_vld[j] = 1; e_dat[j] = xyz; e_trs[j] = 1; e_mis[j] = 0; e_fvh[j] = f3;
        end else begin
            mis = 1; e_mis[j] = 1;
        end
    endtask

    task automatic do_reset(bit fo, bit re);
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
        follow_off = fo; realign_en = re;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(word_out == 0 && !word_vld && !trs_pulse && !misalign &&
            {flag_f, flag_v, flag_h} == 3'b000, "R1", "reset outputs",
            {word_out, word_vld, trs_pulse, misalign, flag_f, flag_v, flag_h}, 0);
    endtask

    task automatic play(string dt, string mt, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 7 == 3)) begin
                bit_en = 1'b0; bit_in = ~sb[i];
                @(posedge clk); #1;
                chk(!word_vld, "R10", "idle word_vld", word_vld, 0);
                if (i > 0) begin
                    chk(misalign == e_mis[i-1], "R10", "idle misalign", misalign, e_mis[i-1]);
                    chk({flag_f, flag_v, flag_h} == e_fvh[i-1], "R10", "idle flags",
                        {flag_f, flag_v, flag_h}, e_fvh[i-1]);
                end
            end
            bit_en = 1'b1; bit_in = sb[i];
            @(posedge clk); #1;
            chk(word_vld == e_vld[i], (i < first_lock) ? "R1" : dt, "word_vld", word_vld, e_vld[i]);
            if (e_vld[i]) begin
                chk(word_out == e_dat[i], e_trs[i] ? "R2" : dt, "word_out", word_out, e_dat[i]);
                chk(trs_pulse == e_trs[i], "R9", "trs_pulse", trs_pulse, e_trs[i]);
            end else begin
                chk(!trs_pulse, "R9", "trs_pulse w/o word", trs_pulse, 0);
            end
            chk(misalign == e_mis[i], mt, "misalign", misalign, e_mis[i]);
            chk({flag_f, flag_v, flag_h} == e_fvh[i], "R8", "flags",
                {flag_f, flag_v, flag_h}, e_fvh[i]);
        end
        bit_en = 1'b0;
    endtask

    task automatic build_auto();
        build_init();
        put_slip(3); put_fill(5); put_trs(3'b101, 1); put_fill(6);
        put_slip(4); put_fill(3); put_trs(3'b010, 0); put_fill(4);
        put_trs(3'b011, 1); put_fill(5);
    endtask

    initial begin
        fc = 0;
        // auto-follow policy (inputs tied low), R7
        do_reset(1'b0, 1'b0);
        build_auto();
        play("R3", "R7", 1'b0);
        // lock-once policy, R4 and R5
        do_reset(1'b1, 1'b0);
        build_init();
        put_slip(2); put_fill(4); put_trs(3'b110, 1); put_fill(5);
        put_slip(3); put_fill(2); put_trs(3'b001, 0); put_fill(3);
        put_trs(3'b111, 0); put_fill(2);
        put_slip(7); put_fill(2); put_trs(3'b100, 1); put_fill(4);
        play("R4", "R5", 1'b0);
        // realign-on-every policy, R6
        do_reset(1'b1, 1'b1);
        build_init();
        put_slip(5); put_fill(3); put_trs(3'b001, 1); put_fill(3);
        put_slip(6); put_trs(3'b010, 1); put_fill(2);
        put_slip(2); put_fill(1); put_trs(3'b111, 1); put_fill(3);
        play("R6", "R6", 1'b0);
        // auto-follow with idle clocks between bits, R10
        do_reset(1'b0, 1'b0);
        build_auto();
        play("R10", "R7", 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule